// File: doc/BRIEF.md
# Address Window Map Decoder

This block decides, for every bus cycle seen by a bridge between a local and a remote bus, whether the cycle is carried across. The cycle is described by a 24-bit address and its origin (local or remote). A single 16-bit register describes one window over the top eight address bits, the "page". The window belongs to one crossing direction. Addresses inside it cross in that direction, and addresses outside it cross the other way.

A mode input picks how the register is read as a range. In base/size mode, the low byte is a base page and a 3-bit code sets how many leading page bits must match it. The enable and direction flags also live in the register. In bounds mode, the upper byte is an exclusive upper page and the lower byte an inclusive lower page, and the enable and direction come from two separate inputs. The decision is combinational from the address, the origin and the register contents. The register is written through a simple write strobe and cleared by an asynchronous hard reset.

Top module: `addrwin_map`

## Requirements
- R1: An active-high hard reset clears all 16 stored bits. Afterwards a base/size read returns 16'h1800, a bounds read returns 16'h0000, and `map_across` stays low.
- R2: With `reg_we` high at a rising clock edge, `reg_wdata` is stored and visible on `reg_rdata` from that edge onward. Without the strobe, the stored value is held.
- R3: In base/size mode (`bound_mode`=0), `reg_rdata` returns bit 15 as 0 and bits 12 and 11 as 1. Every other bit returns as stored.
- R4: In bounds mode (`bound_mode`=1), `reg_rdata` returns all 16 stored bits unchanged.
- R5: `map_across` is 0 for every address and origin when the active enable is 0. The active enable is stored bit 14 in base/size mode and the `bnd_enable` input in bounds mode.
- R6: In base/size mode with size code s (stored bits 10:8) and base page b (stored bits 7:0), an address is in range when the upper s+1 bits of address bits 23:16 equal those of b. Code 0 compares only bit 23, and code 7 compares all eight bits. Address bits 15:0 never affect the result.
- R7: In bounds mode, an address is in range when lower ≤ addr[23:16] < upper. Upper is stored bits 15:8 and lower is stored bits 7:0, so upper ≤ lower gives an empty range.
- R8: An enabled in-range cycle is mapped when its origin (`cyc_from_remote`, 1 = remote) equals the active direction (1 = inward). The active direction is stored bit 13 in base/size mode and `bnd_inward` in bounds mode.
- R9: An enabled out-of-range cycle is mapped when its origin differs from the active direction.
- R10: `map_across` follows address, origin, mode and the bounds-mode inputs with no clock delay. A register write changes it only after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Asynchronous active-high hard reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, format per mode |
| bound_mode | input | 1 | 0 = base/size window, 1 = lower/upper bounds |
| bnd_enable | input | 1 | Window enable used in bounds mode |
| bnd_inward | input | 1 | Window direction used in bounds mode (1 = inward) |
| cyc_addr | input | 24 | Address of the current bus cycle |
| cyc_from_remote | input | 1 | Cycle origin: 1 = remote side, 0 = local side |
| map_across | output | 1 | Cycle is to be carried across the bridge |

## Verification
A register write and a cycle decode can land in the same clock period. The decode then has to use the window as it stood before the edge. The bench sets up a window that maps a cycle. In the same low phase it raises the strobe with a value that disables or moves the window. It samples `map_across` before the edge, where the old window must still decide, and again after the edge, where the new value must decide. The same collision is repeated with a mode flip, which reinterprets the stored bits combinationally without any edge.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;

   typedef enum logic {
      WIN_BASE_SIZE = 1'b0,
      WIN_BOUNDS    = 1'b1
   } win_mode_e;

   typedef struct packed {
      logic enable;
      logic inward;
   } win_ctl_t;

endpackage

// File: rtl/addrwin_reg.sv
module addrwin_reg #(
   parameter int REG_W  = 16,
   parameter int PAGE_W = 8,
   parameter int SIZE_W = 3
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         we,
   input  logic [REG_W-1:0]             wdata,
   input  addrwin_pkg::win_mode_e       mode,
   output logic [REG_W-1:0]             stored,
   output logic [REG_W-1:0]             rdata
);
   import addrwin_pkg::*;

   localparam int RSV_BIT = REG_W - 1;
   localparam int ONE_HI  = REG_W - 4;
   localparam int ONE_LO  = PAGE_W + SIZE_W;

   if (ONE_HI < ONE_LO) begin : g_bad_layout
      $error("addrwin_reg: no room for fixed-one bits");
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)     stored <= '0;
      else if (we) stored <= wdata;
   end

   always_comb begin
      rdata = stored;
      if (mode == WIN_BASE_SIZE) begin
         rdata[RSV_BIT]        = 1'b0;
         rdata[ONE_HI:ONE_LO]  = '1;
      end
   end

   assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
      we |=> stored == $past(wdata));
   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(stored));
   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> stored == '0);

endmodule

// File: rtl/addrwin_cmp.sv
module addrwin_cmp #(
   parameter int REG_W  = 16,
   parameter int PAGE_W = 8,
   parameter int SIZE_W = 3
) (
   input  addrwin_pkg::win_mode_e mode,
   input  logic [REG_W-1:0]       stored,
   input  logic [PAGE_W-1:0]      page,
   output logic                   hit
);
   import addrwin_pkg::*;

   logic [PAGE_W-1:0] base_pg;
   logic [SIZE_W-1:0] size_code;
   logic [PAGE_W-1:0] upper_pg;
   logic [PAGE_W-1:0] lower_pg;
   logic [PAGE_W-1:0] cmp_mask;
   logic              hit_bs;
   logic              hit_bd;

   assign base_pg   = stored[PAGE_W-1:0];
   assign size_code = stored[PAGE_W+SIZE_W-1:PAGE_W];
   assign upper_pg  = stored[REG_W-1:PAGE_W];
   assign lower_pg  = stored[PAGE_W-1:0];

   // bit i of the page takes part when it lies within the top size_code+1 bits
   for (genvar i = 0; i < PAGE_W; i++) begin : g_mask
      assign cmp_mask[i] = (32'(size_code) >= (PAGE_W - 1 - i));
   end

   assign hit_bs = ((page ^ base_pg) & cmp_mask) == '0;
   assign hit_bd = (page >= lower_pg) && (page < upper_pg);
   assign hit    = (mode == WIN_BOUNDS) ? hit_bd : hit_bs;

endmodule

// File: rtl/addrwin_route.sv
module addrwin_route (
   input  addrwin_pkg::win_ctl_t ctl,
   input  logic                  hit,
   input  logic                  from_remote,
   output logic                  map
);
   logic origin_matches;

   assign origin_matches = (from_remote == ctl.inward);
   assign map = ctl.enable && (hit ? origin_matches : !origin_matches);

endmodule

// File: rtl/addrwin_map.sv
module addrwin_map #(
   parameter int ADDR_W = 24,
   parameter int PAGE_W = 8,
   parameter int SIZE_W = 3,
   parameter int REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_we,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              bound_mode,
   input  logic              bnd_enable,
   input  logic              bnd_inward,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic              cyc_from_remote,
   output logic              map_across
);
   import addrwin_pkg::*;

   localparam int EN_BIT  = REG_W - 2;
   localparam int DIR_BIT = REG_W - 3;
   localparam int LOW_W   = ADDR_W - PAGE_W;

   if (REG_W != 2 * PAGE_W) begin : g_bad_reg
      $error("addrwin_map: register must hold two pages");
   end
   if ((1 << SIZE_W) != PAGE_W) begin : g_bad_size
      $error("addrwin_map: size code must span the page width");
   end
   if (LOW_W < 1) begin : g_bad_addr
      $error("addrwin_map: address must be wider than the page");
   end

   win_mode_e         mode;
   logic [REG_W-1:0]  stored;
   logic [PAGE_W-1:0] page;
   logic              hit;
   win_ctl_t          ctl;
   wire               unused_low_bits = ^cyc_addr[LOW_W-1:0];

   assign mode = win_mode_e'(bound_mode);
   assign page = cyc_addr[ADDR_W-1 -: PAGE_W];

   always_comb begin
      if (mode == WIN_BOUNDS) begin
         ctl.enable = bnd_enable;
         ctl.inward = bnd_inward;
      end else begin
         ctl.enable = stored[EN_BIT];
         ctl.inward = stored[DIR_BIT];
      end
   end

   addrwin_reg #(.REG_W(REG_W), .PAGE_W(PAGE_W), .SIZE_W(SIZE_W)) u_reg (
      .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata),
      .mode(mode), .stored(stored), .rdata(reg_rdata));

   addrwin_cmp #(.REG_W(REG_W), .PAGE_W(PAGE_W), .SIZE_W(SIZE_W)) u_cmp (
      .mode(mode), .stored(stored), .page(page), .hit(hit));

   addrwin_route u_route (
      .ctl(ctl), .hit(hit), .from_remote(cyc_from_remote), .map(map_across));

   assert_readback_fixed_R3: assert property (@(posedge clk) disable iff (rst)
      !bound_mode |-> (reg_rdata[REG_W-1] == 1'b0 && reg_rdata[REG_W-4 -: 2] == 2'b11));
   assert_disabled_idle_R5: assert property (@(posedge clk) disable iff (rst)
      ((!bound_mode && !reg_rdata[EN_BIT]) || (bound_mode && !bnd_enable)) |-> !map_across);
   assert_full_match_R6: assert property (@(posedge clk) disable iff (rst)
      (!bound_mode && reg_rdata[EN_BIT] && reg_rdata[PAGE_W +: SIZE_W] == '1
       && page == reg_rdata[PAGE_W-1:0]) |-> map_across == (cyc_from_remote == reg_rdata[DIR_BIT]));
   assert_bounds_inside_R8: assert property (@(posedge clk) disable iff (rst)
      (bound_mode && bnd_enable && page >= reg_rdata[PAGE_W-1:0] && page < reg_rdata[REG_W-1:PAGE_W])
      |-> map_across == (cyc_from_remote == bnd_inward));
   assert_bounds_outside_R9: assert property (@(posedge clk) disable iff (rst)
      (bound_mode && bnd_enable && (page < reg_rdata[PAGE_W-1:0] || page >= reg_rdata[REG_W-1:PAGE_W]))
      |-> map_across == (cyc_from_remote != bnd_inward));

endmodule

// File: tb/addrwin_map_test.sv
module addrwin_map_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_we = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        bound_mode = 1'b0;
   logic        bnd_enable = 1'b0;
   logic        bnd_inward = 1'b0;
   logic [23:0] cyc_addr = '0;
   logic        cyc_from_remote = 1'b0;
   logic        map_across;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   addrwin_map uut (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .bound_mode(bound_mode), .bnd_enable(bnd_enable),
      .bnd_inward(bnd_inward), .cyc_addr(cyc_addr),
      .cyc_from_remote(cyc_from_remote), .map_across(map_across));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [15:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   function automatic logic model(input logic mode, input logic [15:0] r,
                                  input logic en_in, input logic dir_in,
                                  input logic [7:0] pg, input logic remote);
      logic hit, en, dir;
      int ws;
      if (!mode) begin
         ws  = 1 << (7 - int'(r[10:8]));
         hit = (int'(pg) / ws) == (int'(r[7:0]) / ws);
         en  = r[14]; dir = r[13];
      end else begin
         hit = (pg >= r[7:0]) && (pg < r[15:8]);
         en  = en_in; dir = dir_in;
      end
      if (!en) return 1'b0;
      return hit ? (remote == dir) : (remote != dir);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] rv;
      logic [15:0] bases [3];
      logic [15:0] bnds [6];
      bases = '{16'h0000, 16'h00A5, 16'h00FF};
      bnds  = '{16'h2010, 16'h1020, 16'hFF00, 16'h4140, 16'h0000, 16'h8080};

      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: cleared state in both read formats, window silent
      chk("R1 rdata base/size", reg_rdata, 16'h1800);
      bound_mode = 1'b1; #1;
      chk("R1 rdata bounds", reg_rdata, 16'h0000);
      bound_mode = 1'b0;
      for (int p = 0; p < 256; p += 17) begin
         cyc_addr = {8'(p), 16'h1234}; cyc_from_remote = p[0]; #1;
         chk("R1 map after reset", map_across, 1'b0);
      end

      // R2/R3/R4 readback formats
      wr(16'hFFFF);
      chk("R3 all-ones base/size read", reg_rdata, 16'h7FFF);
      bound_mode = 1'b1; #1;
      chk("R4 all-ones bounds read", reg_rdata, 16'hFFFF);
      wr(16'h8421);
      chk("R2 R4 stored pattern", reg_rdata, 16'h8421);
      bound_mode = 1'b0; #1;
      chk("R3 pattern base/size read", reg_rdata, 16'h1C21);
      @(negedge clk); reg_wdata = 16'h5555; @(negedge clk);
      chk("R2 held without strobe", reg_rdata, 16'h1C21);

      // R5 R6 R8 R9: base/size sweep
      for (int s = 0; s < 8; s++)
         for (int b = 0; b < 3; b++)
            for (int e = 0; e < 2; e++)
               for (int d = 0; d < 2; d++) begin
                  rv = 16'((e << 14) | (d << 13) | (s << 8)) | bases[b];
                  wr(rv);
                  for (int p = 0; p < 256; p++)
                     for (int o = 0; o < 2; o++) begin
                        cyc_addr = {8'(p), 16'(p * 257) ^ 16'h5A3C};
                        cyc_from_remote = o[0]; #1;
                        chk(e ? "R6 R8 R9 base/size map" : "R5 base/size disabled",
                            map_across, model(1'b0, rv, 1'b0, 1'b0, 8'(p), o[0]));
                     end
               end

      // R5 R7 R8 R9: bounds sweep
      bound_mode = 1'b1;
      for (int b = 0; b < 6; b++) begin
         wr(bnds[b]);
         for (int e = 0; e < 2; e++)
            for (int d = 0; d < 2; d++) begin
               bnd_enable = e[0]; bnd_inward = d[0];
               for (int p = 0; p < 256; p++)
                  for (int o = 0; o < 2; o++) begin
                     cyc_addr = {8'(p), 16'(p * 131)};
                     cyc_from_remote = o[0]; #1;
                     chk(e ? "R7 R8 R9 bounds map" : "R5 bounds disabled",
                         map_across, model(1'b1, bnds[b], e[0], d[0], 8'(p), o[0]));
                  end
            end
      end

      // R10: write colliding with a decode in the same period
      bound_mode = 1'b0;
      wr(16'h6730);
      @(negedge clk);
      cyc_addr = 24'h30ABCD; cyc_from_remote = 1'b1;
      reg_we = 1'b1; reg_wdata = 16'h2730;
      #5;
      chk("R10 old window before edge", map_across, 1'b1);
      @(posedge clk); #1;
      chk("R10 new window after edge", map_across, 1'b0);
      reg_we = 1'b0;
      @(negedge clk);
      reg_we = 1'b1; reg_wdata = 16'h6731;
      #5;
      chk("R10 disabled before edge", map_across, 1'b0);
      @(posedge clk); #1;
      chk("R10 moved window after edge", map_across, 1'b0);
      cyc_from_remote = 1'b0; #1;
      chk("R9 R10 outside moved window", map_across, 1'b1);
      reg_we = 1'b0;
      // mode flip reinterprets without an edge: bounds lower 0x31 upper 0x67
      @(negedge clk);
      bnd_enable = 1'b1; bnd_inward = 1'b0; bound_mode = 1'b1; #1;
      chk("R10 mode flip outside bounds", map_across, 1'b0);
      cyc_addr = 24'h500000; #1;
      chk("R7 R10 mode flip inside bounds", map_across, 1'b1);

      // R1: hard reset clears mid-run
      rst = 1'b1; #1;
      chk("R1 async clear", reg_rdata, 16'h0000);
      bound_mode = 1'b0; #1;
      chk("R1 map after hard reset", map_across, 1'b0);
      @(negedge clk); rst = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule